// File: doc/BRIEF.md
# Partitioned Flash Command Decoder

This block models the command interface of a NOR flash whose address space is split into equal partitions. Every bus write is treated as a command cycle. The block decodes single-cycle mode commands and three two-cycle sequences: setting the configuration word, clearing the lock bit of the protection area, and programming one of four protection words. Each partition keeps its own read mode. A read of a partition returns a word from a small computed array, the status word, or a word from the configuration space, depending on that partition's mode.

A two-cycle sequence starts with a setup write, which also switches the addressed partition to status mode. Reads may be made before the confirm write without disturbing the pending sequence. The partition under setup then shows status, while every other partition keeps its own mode. The next write after a setup is always taken as the confirm. If it does not match, the sequence is cancelled, nothing is written and an error bit is raised. The partition number is `addr[ADDR_W-1 -: PART_BITS]` (bits 17:16 by default). The low 16 address bits are the in-partition address, and the array offset is `addr[OFF_W-1:0]`. Command codes are decoded from `wr_data[7:0]`.

The sequencer has four states. SQ_IDLE goes to SQ_CFG on a 60h write. It goes to SQ_LOCK on C0h written at low address 0080h, and to SQ_PROT on C0h written at low address 0084h–0087h. SQ_CFG, SQ_LOCK and SQ_PROT all return to SQ_IDLE on the next write, whether that write confirms or cancels. No other write leaves SQ_IDLE.

Top module: `pflash_cmd_if`

## Requirements
- R1: After reset every partition is in array mode, no sequence is pending, the status word is 0080h, the configuration word is CFG_INIT (BFCFh by default), and the lock word and all four protection words are FFFFh.
- R2: In array mode, a read of partition p at offset o returns A000h + 100h·p + 11h·o.
- R3: In SQ_IDLE, writing FFh, 70h or 90h sets only the addressed partition to array, status or configuration mode respectively. In configuration mode, low address 0005h returns the configuration word, 0080h the lock word, 0084h+i protection word i, and any other address 0000h.
- R4: A setup write (60h, or C0h at any address) puts the addressed partition in status mode. Status reads return bit 7 = 1 (ready), bit 4 = sequence error and bit 1 = lock error, with all other bits 0.
- R5: Reads made between setup and confirm do not cancel the sequence, and a read of any other partition returns data for that partition's own mode.
- R6: 60h followed by a write with low byte 03h, at any address in any partition, loads the confirm write's addr[15:0] into the configuration word.
- R7: C0h at low address 0080h followed by the full word FFFDh at low address 0080h ANDs the lock word with FFFDh. Bits of the lock word never return from 0 to 1.
- R8: C0h at low address 0084h+i (i = 0..3) followed by a write at the identical full address ANDs protection word i with the written data.
- R9: A confirm write with the wrong value (including FFh), or at the wrong address, cancels the sequence, writes nothing and sets status bit 4. A C0h write at a low address outside 0080h and 0084h–0087h sets status bit 4 and starts no sequence. Any write in a pending state returns the sequencer to SQ_IDLE.
- R10: A valid protection-word confirm while lock word bit 1 is 0 writes nothing and sets status bit 1.
- R11: Writing 50h in SQ_IDLE clears status bits 4 and 1 and leaves every read mode unchanged.
- R12: In SQ_IDLE, a write whose low byte is not FFh, 70h, 90h, 50h, 60h or C0h changes no mode, register or status bit.
- R13: A read strobe in one cycle gives rd_valid high and rd_data valid in the next cycle. rd_valid is low in any cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one command cycle per high clock |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Partition number in the top bits, in-partition address below |
| wr_data | input | 16 | Command or data word |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read |

## Verification
The assertions assume that reset is held low across at least one rising edge before any strobe. They also assume that wr_en, rd_en, addr and wr_data carry known values whenever reset is released. The stimulus drives every input only on falling edges and holds each strobe for exactly one cycle. It never raises write and read in the same cycle, so every assertion window has a single cause. Reset is held for several cycles before the first command.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int DATA_W     = 16;
    localparam int PROT_WORDS = 4;
    localparam int PROT_IDX_W = $clog2(PROT_WORDS);

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_CONFIG = 2'd2
    } rmode_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CFG  = 2'd1,
        SQ_LOCK = 2'd2,
        SQ_PROT = 2'd3
    } sq_t;

    localparam logic [7:0] OP_MODE_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_MODE_STATUS = 8'h70;
    localparam logic [7:0] OP_MODE_CONFIG = 8'h90;
    localparam logic [7:0] OP_STAT_CLEAR  = 8'h50;
    localparam logic [7:0] OP_CFG_SETUP   = 8'h60;
    localparam logic [7:0] OP_CFG_CONFIRM = 8'h03;
    localparam logic [7:0] OP_PROT_SETUP  = 8'hC0;

    localparam word_t LOCK_KEY = 16'hFFFD;
    localparam word_t LOCK_LOC = 16'h0080;
    localparam word_t PROT_LOC = 16'h0084;
    localparam word_t PROT_END = PROT_LOC + 16'(PROT_WORDS);
    localparam word_t CFG_LOC  = 16'h0005;

    localparam int STAT_READY    = 7;
    localparam int STAT_SEQ_ERR  = 4;
    localparam int STAT_LOCK_ERR = 1;
    localparam int LOCK_BIT      = 1;

    function automatic word_t array_word(input int unsigned part, input int unsigned off);
        array_word = word_t'(32'hA000 + part * 32'h100 + off * 32'h11);
    endfunction

    function automatic logic in_prot_window(input word_t low);
        in_prot_window = (low >= PROT_LOC) && (low < PROT_END);
    endfunction
endpackage

// File: rtl/pfc_mode_table.sv
module pfc_mode_table
    import pfc_pkg::*;
#(
    parameter int PART_BITS = 2,
    localparam int NPART = 1 << PART_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [PART_BITS-1:0] set_part,
    input  rmode_t               set_mode,
    input  logic [PART_BITS-1:0] look_part,
    output rmode_t               look_mode
);
    rmode_t modes [NPART];

    for (genvar g = 0; g < NPART; g++) begin : g_part
        rmode_t mode_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q <= RM_ARRAY;
            end else if (set_en && set_part == PART_BITS'(g)) begin
                mode_q <= set_mode;
            end
        end
        assign modes[g] = mode_q;
    end

    assign look_mode = modes[look_part];
endmodule

// File: rtl/pfc_array.sv
module pfc_array
    import pfc_pkg::*;
#(
    parameter int PART_BITS = 2,
    parameter int OFF_W     = 3
) (
    input  logic [PART_BITS-1:0] part,
    input  logic [OFF_W-1:0]     off,
    output word_t                data
);
    assign data = array_word(32'(part), 32'(off));
endmodule

// File: rtl/pfc_seq_fsm.sv
module pfc_seq_fsm
    import pfc_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int PART_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  word_t                 wdata,
    input  logic                  lock_open,
    output sq_t                   state,
    output logic                  mode_we,
    output logic [PART_BITS-1:0]  mode_part,
    output rmode_t                mode_val,
    output logic                  cfg_we,
    output word_t                 cfg_val,
    output logic                  lock_we,
    output logic                  prot_we,
    output logic [PROT_IDX_W-1:0] prot_idx,
    output word_t                 prot_val,
    output logic                  seq_err_set,
    output logic                  lock_err_set,
    output logic                  stat_clr
);
    sq_t               state_q, state_d;
    logic [ADDR_W-1:0] pend_q;
    word_t             low, pend_low;
    logic [7:0]        op;
    logic              hit_lock, hit_prot;

    assign low      = addr[15:0];
    assign pend_low = pend_q[15:0];
    assign op       = wdata[7:0];
    assign hit_lock = (low == LOCK_LOC);
    assign hit_prot = in_prot_window(low);
    assign state    = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr_en && state_q == SQ_IDLE) begin
                pend_q <= addr;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (op == OP_CFG_SETUP) begin
                        state_d = SQ_CFG;
                    end else if (op == OP_PROT_SETUP && hit_lock) begin
                        state_d = SQ_LOCK;
                    end else if (op == OP_PROT_SETUP && hit_prot) begin
                        state_d = SQ_PROT;
                    end
                end
                SQ_CFG:  state_d = SQ_IDLE;
                SQ_LOCK: state_d = SQ_IDLE;
                SQ_PROT: state_d = SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        mode_we      = 1'b0;
        mode_part    = addr[ADDR_W-1 -: PART_BITS];
        mode_val     = RM_ARRAY;
        cfg_we       = 1'b0;
        cfg_val      = low;
        lock_we      = 1'b0;
        prot_we      = 1'b0;
        prot_idx     = PROT_IDX_W'(pend_low - PROT_LOC);
        prot_val     = wdata;
        seq_err_set  = 1'b0;
        lock_err_set = 1'b0;
        stat_clr     = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                SQ_IDLE: begin
                    case (op)
                        OP_MODE_ARRAY: begin
                            mode_we  = 1'b1;
                            mode_val = RM_ARRAY;
                        end
                        OP_MODE_STATUS: begin
                            mode_we  = 1'b1;
                            mode_val = RM_STATUS;
                        end
                        OP_MODE_CONFIG: begin
                            mode_we  = 1'b1;
                            mode_val = RM_CONFIG;
                        end
                        OP_STAT_CLEAR: stat_clr = 1'b1;
                        OP_CFG_SETUP: begin
                            mode_we  = 1'b1;
                            mode_val = RM_STATUS;
                        end
                        OP_PROT_SETUP: begin
                            mode_we  = 1'b1;
                            mode_val = RM_STATUS;
                            if (!hit_lock && !hit_prot) begin
                                seq_err_set = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                SQ_CFG: begin
                    if (op == OP_CFG_CONFIRM) cfg_we = 1'b1;
                    else                      seq_err_set = 1'b1;
                end
                SQ_LOCK: begin
                    if (wdata == LOCK_KEY && hit_lock) lock_we = 1'b1;
                    else                               seq_err_set = 1'b1;
                end
                SQ_PROT: begin
                    if (addr != pend_q)  seq_err_set  = 1'b1;
                    else if (lock_open)  prot_we      = 1'b1;
                    else                 lock_err_set = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/pfc_regs.sv
module pfc_regs
    import pfc_pkg::*;
#(
    parameter word_t CFG_INIT = 16'hBFCF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  word_t                 cfg_val,
    input  logic                  lock_we,
    input  logic                  prot_we,
    input  logic [PROT_IDX_W-1:0] prot_idx,
    input  word_t                 prot_val,
    input  logic                  seq_err_set,
    input  logic                  lock_err_set,
    input  logic                  stat_clr,
    output word_t                 cfg_word,
    output word_t                 lock_word,
    output word_t                 prot_words [PROT_WORDS],
    output word_t                 status_word
);
    logic seq_err_q, lock_err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_word   <= CFG_INIT;
            lock_word  <= '1;
            seq_err_q  <= 1'b0;
            lock_err_q <= 1'b0;
        end else begin
            if (cfg_we)  cfg_word  <= cfg_val;
            if (lock_we) lock_word <= lock_word & LOCK_KEY;
            if (stat_clr) begin
                seq_err_q  <= 1'b0;
                lock_err_q <= 1'b0;
            end else begin
                if (seq_err_set)  seq_err_q  <= 1'b1;
                if (lock_err_set) lock_err_q <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < PROT_WORDS; g++) begin : g_prot
        word_t pw_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pw_q <= '1;
            end else if (prot_we && prot_idx == PROT_IDX_W'(g)) begin
                pw_q <= pw_q & prot_val;
            end
        end
        assign prot_words[g] = pw_q;
    end

    always_comb begin
        status_word                = '0;
        status_word[STAT_READY]    = 1'b1;
        status_word[STAT_SEQ_ERR]  = seq_err_q;
        status_word[STAT_LOCK_ERR] = lock_err_q;
    end
endmodule

// File: rtl/pflash_cmd_if.sv
module pflash_cmd_if
    import pfc_pkg::*;
#(
    parameter int    ADDR_W    = 18,
    parameter int    PART_BITS = 2,
    parameter int    OFF_W     = 3,
    parameter word_t CFG_INIT  = 16'hBFCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              rd_valid
);
    sq_t                   seq_state;
    logic                  mode_we;
    logic [PART_BITS-1:0]  mode_part;
    rmode_t                mode_val, look_mode;
    logic                  cfg_we, lock_we, prot_we;
    word_t                 cfg_val, prot_val;
    logic [PROT_IDX_W-1:0] prot_idx;
    logic                  seq_err_set, lock_err_set, stat_clr;
    word_t                 cfg_word, lock_word, status_word, arr_data, cfg_space;
    word_t                 prot_words [PROT_WORDS];
    word_t                 low;
    logic [PART_BITS-1:0]  part;

    assign low  = addr[15:0];
    assign part = addr[ADDR_W-1 -: PART_BITS];

    pfc_seq_fsm #(.ADDR_W(ADDR_W), .PART_BITS(PART_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wr_data),
        .lock_open(lock_word[LOCK_BIT]), .state(seq_state),
        .mode_we(mode_we), .mode_part(mode_part), .mode_val(mode_val),
        .cfg_we(cfg_we), .cfg_val(cfg_val), .lock_we(lock_we),
        .prot_we(prot_we), .prot_idx(prot_idx), .prot_val(prot_val),
        .seq_err_set(seq_err_set), .lock_err_set(lock_err_set), .stat_clr(stat_clr)
    );

    pfc_mode_table #(.PART_BITS(PART_BITS)) u_modes (
        .clk(clk), .rst_n(rst_n), .set_en(mode_we), .set_part(mode_part),
        .set_mode(mode_val), .look_part(part), .look_mode(look_mode)
    );

    pfc_regs #(.CFG_INIT(CFG_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_val(cfg_val),
        .lock_we(lock_we), .prot_we(prot_we), .prot_idx(prot_idx), .prot_val(prot_val),
        .seq_err_set(seq_err_set), .lock_err_set(lock_err_set), .stat_clr(stat_clr),
        .cfg_word(cfg_word), .lock_word(lock_word), .prot_words(prot_words),
        .status_word(status_word)
    );

    pfc_array #(.PART_BITS(PART_BITS), .OFF_W(OFF_W)) u_array (
        .part(part), .off(addr[OFF_W-1:0]), .data(arr_data)
    );

    always_comb begin
        if (low == CFG_LOC)           cfg_space = cfg_word;
        else if (low == LOCK_LOC)     cfg_space = lock_word;
        else if (in_prot_window(low)) cfg_space = prot_words[PROT_IDX_W'(low - PROT_LOC)];
        else                          cfg_space = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                unique case (look_mode)
                    RM_ARRAY:  rd_data <= arr_data;
                    RM_STATUS: rd_data <= status_word;
                    RM_CONFIG: rd_data <= cfg_space;
                    default:   rd_data <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pflash_cmd_if_chk.sv
module pflash_cmd_if_chk
    import pfc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] wr_data,
    input logic        rd_valid,
    input sq_t         seq_state,
    input word_t       cfg_word,
    input word_t       lock_word
);
    p_rd_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_no_spurious_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_pending_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != SQ_IDLE && wr_en) |=> (seq_state == SQ_IDLE));

    p_setup_enters_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_IDLE && wr_en && wr_data[7:0] == OP_CFG_SETUP) |=> (seq_state == SQ_CFG));

    p_cfg_only_confirm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word != $past(cfg_word)) |->
            ($past(seq_state) == SQ_CFG && $past(wr_en) && $past(wr_data[7:0]) == OP_CFG_CONFIRM));

    p_lock_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_word & ~$past(lock_word)) == '0);
endmodule

bind pflash_cmd_if pflash_cmd_if_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .rd_valid(rd_valid), .seq_state(seq_state), .cfg_word(cfg_word), .lock_word(lock_word)
);

// File: tb/pflash_cmd_if_test.sv
`timescale 1ns/1ps
module pflash_cmd_if_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    int n_cmp = 0;
    int n_err = 0;
    logic [15:0] q;
    logic [15:0] exp_cfg, exp_lock;
    logic [15:0] exp_prot [4];

    always #4 clk = ~clk;

    pflash_cmd_if uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [17:0] mk(input int p, input logic [15:0] lo);
        return {2'(p), lo};
    endfunction

    function automatic logic [15:0] arr(input int p, input int o);
        return 16'(32'hA000 + p * 256 + o * 17);
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [17:0] a, output logic [15:0] r);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R13 rd_valid after strobe", 16'(rd_valid), 16'h1);
        r = rd_data;
    endtask

    task automatic chk_cfgspace(input string tag);
        rd(mk(3, 16'h0005), q); chk({tag, " cfg word"}, q, exp_cfg);
        rd(mk(3, 16'h0080), q); chk({tag, " lock word"}, q, exp_lock);
        for (int i = 0; i < 4; i++) begin
            rd(mk(3, 16'(16'h0084 + i)), q);
            chk({tag, " prot word"}, q, exp_prot[i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        exp_cfg = 16'hBFCF; exp_lock = 16'hFFFF;
        for (int i = 0; i < 4; i++) exp_prot[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 rd_valid idle", 16'(rd_valid), 16'h0);

        // R1 R2: every partition reads array data after reset
        for (int p = 0; p < 4; p++)
            for (int o = 0; o < 8; o++) begin
                rd(mk(p, 16'(o)), q);
                chk("R2 array word", q, arr(p, o));
            end
        @(negedge clk);
        chk("R13 rd_valid drops", 16'(rd_valid), 16'h0);

        // R1 R3: status and configuration space reset values
        wr(mk(0, 16'h0000), 16'h0070);
        rd(mk(0, 16'h0003), q); chk("R1 status reset", q, 16'h0080);
        wr(mk(3, 16'h0000), 16'h0090);
        chk_cfgspace("R1 reset");
        rd(mk(3, 16'h0010), q); chk("R3 cfg space other", q, 16'h0000);
        rd(mk(2, 16'h0003), q); chk("R3 other partition array", q, arr(2, 3));
        rd(mk(1, 16'h0006), q); chk("R3 other partition array", q, arr(1, 6));
        wr(mk(2, 16'h0000), 16'h0070);
        rd(mk(2, 16'h0001), q); chk("R3 status mode", q, 16'h0080);
        wr(mk(2, 16'h0000), 16'h00FF);
        rd(mk(2, 16'h0004), q); chk("R3 back to array", q, arr(2, 4));

        // R12: undefined codes ignored
        wr(mk(2, 16'h0000), 16'h0000);
        wr(mk(2, 16'h0080), 16'h0020);
        wr(mk(2, 16'h0084), 16'h00D0);
        wr(mk(2, 16'h0005), 16'h00B0);
        wr(mk(2, 16'h0001), 16'h0041);
        rd(mk(2, 16'h0005), q); chk("R12 mode unchanged", q, arr(2, 5));
        rd(mk(0, 16'h0000), q); chk("R12 status unchanged", q, 16'h0080);
        chk_cfgspace("R12");

        // R4 R5 R6: interleaved reads, config set from confirm address
        wr(mk(1, 16'h1234), 16'h0060);
        rd(mk(1, 16'h0002), q); chk("R4 setup partition status", q, 16'h0080);
        rd(mk(2, 16'h0005), q); chk("R5 other partition array", q, arr(2, 5));
        rd(mk(3, 16'h0005), q); chk("R5 other partition config", q, exp_cfg);
        wr(mk(2, 16'h4321), 16'h0003);
        exp_cfg = 16'h4321;
        rd(mk(3, 16'h0005), q); chk("R6 config loaded", q, exp_cfg);
        rd(mk(1, 16'h0002), q); chk("R4 still status", q, 16'h0080);

        // R8: program every protection word twice
        for (int i = 0; i < 4; i++) begin
            logic [15:0] d1;
            d1 = 16'(16'h1234 + i * 16'h1111);
            wr(mk(0, 16'(16'h0084 + i)), 16'h00C0);
            wr(mk(0, 16'(16'h0084 + i)), d1);
            exp_prot[i] = exp_prot[i] & d1;
            wr(mk(0, 16'(16'h0084 + i)), 16'h00C0);
            wr(mk(0, 16'(16'h0084 + i)), 16'hF0F0);
            exp_prot[i] = exp_prot[i] & 16'hF0F0;
        end
        chk_cfgspace("R8");
        rd(mk(0, 16'h0000), q); chk("R8 no error", q, 16'h0080);

        // R9 R11: cancelled sequences
        wr(mk(0, 16'h0000), 16'h0060);
        wr(mk(0, 16'h7777), 16'h0005);
        rd(mk(0, 16'h0000), q); chk("R9 bad confirm error", q, 16'h0090);
        chk_cfgspace("R9 bad cfg confirm");
        wr(mk(0, 16'h0000), 16'h0050);
        rd(mk(0, 16'h0000), q); chk("R11 status cleared", q, 16'h0080);

        wr(mk(0, 16'h0000), 16'h0060);
        wr(mk(0, 16'h5555), 16'h00FF);
        rd(mk(0, 16'h0000), q); chk("R9 FFh cancels", q, 16'h0090);
        rd(mk(3, 16'h0005), q); chk("R9 FFh no cfg write", q, exp_cfg);
        wr(mk(0, 16'h0000), 16'h0050);

        wr(mk(0, 16'h0085), 16'h00C0);
        wr(mk(0, 16'h0086), 16'h0000);
        rd(mk(0, 16'h0000), q); chk("R9 address mismatch", q, 16'h0090);
        wr(mk(0, 16'h0000), 16'h0050);
        wr(mk(0, 16'h0085), 16'h00C0);
        wr(mk(1, 16'h0085), 16'h0000);
        rd(mk(0, 16'h0000), q); chk("R9 partition mismatch", q, 16'h0090);
        chk_cfgspace("R9 prot mismatch");
        wr(mk(0, 16'h0000), 16'h0050);

        wr(mk(0, 16'h0200), 16'h00C0);
        rd(mk(0, 16'h0000), q); chk("R9 C0h at bad address", q, 16'h0090);
        wr(mk(0, 16'h0000), 16'h0050);

        wr(mk(0, 16'h0080), 16'h00C0);
        wr(mk(0, 16'h0080), 16'hFFFE);
        rd(mk(0, 16'h0000), q); chk("R9 wrong lock key", q, 16'h0090);
        rd(mk(3, 16'h0080), q); chk("R9 lock unchanged", q, exp_lock);
        wr(mk(0, 16'h0000), 16'h0050);
        rd(mk(0, 16'h0000), q); chk("R11 cleared again", q, 16'h0080);

        // R7: lock the protection area
        wr(mk(1, 16'h0080), 16'h00C0);
        wr(mk(2, 16'h0080), 16'hFFFD);
        exp_lock = 16'hFFFD;
        rd(mk(3, 16'h0080), q); chk("R7 lock word", q, exp_lock);
        rd(mk(1, 16'h0000), q); chk("R7 no error", q, 16'h0080);
        wr(mk(1, 16'h0080), 16'h00C0);
        wr(mk(1, 16'h0080), 16'hFFFD);
        rd(mk(3, 16'h0080), q); chk("R7 second lock", q, exp_lock);

        // R10: programming blocked once locked
        for (int i = 0; i < 4; i++) begin
            wr(mk(0, 16'(16'h0084 + i)), 16'h00C0);
            wr(mk(0, 16'(16'h0084 + i)), 16'h0000);
            rd(mk(0, 16'h0000), q); chk("R10 lock error bit", q, 16'h0082);
            wr(mk(0, 16'h0000), 16'h0050);
            rd(mk(0, 16'h0000), q); chk("R11 clears lock error", q, 16'h0080);
        end
        chk_cfgspace("R10 final");
        rd(mk(2, 16'h0007), q); chk("R5 array intact", q, arr(2, 7));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule